// File: doc/BRIEF.md
# Boot Parameter Table Integrity Checker

This block sits in front of a boot loader and decides whether a boot parameter table is intact before anything in the table is acted on. The table arrives as a stream of 16-bit words, one per cycle when the word-valid input is high. A start pulse opens a new table. The first word gives the table size in bytes, and that size counts the size word itself. The second word holds the stored checksum.

The block keeps a running 16-bit ones-complement sum over every word of the table. When the last word is taken, it raises a one-cycle done pulse together with a pass or fail verdict. A stored checksum of zero turns verification off, and such a table always passes. A strap input sets how the two bytes of each incoming word are ordered. The captured size is made available on an output so the loader can use it.

Top module: `boot_table_checker`

## Requirements
- R1: The first word taken after a start pulse, after byte ordering, is captured as the table size in bytes. It appears on `len_o` from the cycle after that word is accepted and stays there until the next start.
- R2: With `lsb_first_i` = 0 the high byte of `word_i` (bits 15:8) is the first byte and the word is used unchanged. With `lsb_first_i` = 1 the two bytes of every incoming word are swapped before use, and this applies to the size word as well.
- R3: The table is covered by a 16-bit ones-complement sum in which any carry out of bit 15 is added back into bit 0. The table passes when the total over all of its words, the checksum word included, is 0xFFFF or 0x0000. Any other total fails.
- R4: When the second word of the table (byte offset 2) is zero after byte ordering, the table passes whatever the total is.
- R5: A size below 22 bytes fails. In that case done and fail are raised in the cycle after the size word is accepted, and no further words are taken.
- R6: The table holds ceil(size/2) words. When the size is odd, the low byte of the final word after byte ordering is a pad byte and is counted as zero in the sum.
- R7: `done_o` is high for exactly one cycle, namely the cycle after the final word is accepted. While `done_o` is high, exactly one of `pass_o` and `fail_o` is high. That flag stays high until the next start pulse.
- R8: A word is accepted only while `word_vld_i` is high inside an open table. Words presented while valid is low, and words that arrive after the verdict, do not change the count, the sum or any output.
- R9: A start pulse clears the sum, the word count, `len_o`, `pass_o`, `fail_o` and `done_o` in the next cycle and abandons any table in progress. A word presented in the same cycle as the start pulse is not taken.
- R10: After reset, and before the first start pulse, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Opens a new table and abandons any table in progress |
| word_vld_i | input | 1 | Qualifies `word_i` |
| word_i | input | 16 | Incoming table word |
| lsb_first_i | input | 1 | Byte-order strap: 0 = high byte first, 1 = swap the bytes |
| done_o | output | 1 | One-cycle pulse when the verdict is ready |
| pass_o | output | 1 | Table accepted; held until the next start |
| fail_o | output | 1 | Table rejected; held until the next start |
| len_o | output | 16 | Captured table size in bytes |

## Verification
The hardest case to reach from the ports is a final word that carries a pad byte. The pad byte affects the verdict only if the block forgets to zero it. The bench therefore seals a table of odd size with a checksum worked out with the pad zeroed, and it drives a nonzero pattern in the pad position. A block that sums the raw word then reports a failure. An abandoned table is reached by sending part of a table and then pulsing start while a word is valid. The complete table that follows has to pass without any trace of the earlier partial sum.

// File: rtl/btchk_pkg.sv
package btchk_pkg;
   // Words that make up the fixed header of every table
   localparam int unsigned HDR_WORDS_DEF = 11;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } btchk_state_e;
endpackage

// File: rtl/btchk_byte_order.sv
module btchk_byte_order #(
   parameter int unsigned W = 16
) (
   input  logic [W-1:0] raw_i,
   input  logic         swap_i,
   output logic [W-1:0] ord_o
);
   localparam int unsigned NB = W / 8;

   logic [W-1:0] swapped;

   for (genvar b = 0; b < NB; b++) begin : g_lane
      assign swapped[b*8 +: 8] = raw_i[(NB-1-b)*8 +: 8];
   end

   assign ord_o = swap_i ? swapped : raw_i;
endmodule

// File: rtl/btchk_oc_adder.sv
module btchk_oc_adder #(
   parameter int unsigned W = 16
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic [W-1:0] y_o
);
   logic [W:0] raw_sum;

   assign raw_sum = {1'b0, a_i} + {1'b0, b_i};
   // carry out of the top bit goes back into bit 0; this cannot overflow again
   assign y_o = raw_sum[W-1:0] + {{(W-1){1'b0}}, raw_sum[W]};
endmodule

// File: rtl/btchk_seq.sv
module btchk_seq
   import btchk_pkg::*;
#(
   parameter int unsigned W       = 16,
   parameter int unsigned MIN_LEN = 22
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start_i,
   input  logic         vld_i,
   input  logic [W-1:0] word_i,
   input  logic [W-1:0] sum_i,
   output logic [W-1:0] acc_o,
   output logic         last_o,
   output logic         pad_o,
   output logic         done_o,
   output logic         pass_o,
   output logic         fail_o,
   output logic [W-1:0] len_o
);
   btchk_state_e st_q;
   logic [W:0]   cnt_q;
   logic [W:0]   nwords_q;
   logic         skip_q;
   logic [W:0]   len_plus;
   logic         take;
   logic         sum_ok;

   assign take     = (st_q == ST_RUN) && vld_i;
   assign last_o   = (st_q == ST_RUN) && (cnt_q != '0) && ((cnt_q + 1'b1) == nwords_q);
   assign pad_o    = len_o[0];
   assign len_plus = {1'b0, word_i} + {{W{1'b0}}, 1'b1};
   assign sum_ok   = skip_q || (sum_i == '1) || (sum_i == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         cnt_q    <= '0;
         nwords_q <= '0;
         skip_q   <= 1'b0;
         acc_o    <= '0;
         len_o    <= '0;
         done_o   <= 1'b0;
         pass_o   <= 1'b0;
         fail_o   <= 1'b0;
      end else if (start_i) begin
         st_q     <= ST_RUN;
         cnt_q    <= '0;
         nwords_q <= '0;
         skip_q   <= 1'b0;
         acc_o    <= '0;
         len_o    <= '0;
         done_o   <= 1'b0;
         pass_o   <= 1'b0;
         fail_o   <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (take) begin
            cnt_q <= cnt_q + 1'b1;
            acc_o <= sum_i;
            if (cnt_q == '0) begin
               len_o    <= word_i;
               nwords_q <= {1'b0, len_plus[W:1]};
               if (word_i < W'(MIN_LEN)) begin
                  st_q   <= ST_IDLE;
                  done_o <= 1'b1;
                  fail_o <= 1'b1;
               end
            end
            if (cnt_q == {{W{1'b0}}, 1'b1}) begin
               skip_q <= (word_i == '0);
            end
            if (last_o) begin
               st_q   <= ST_IDLE;
               done_o <= 1'b1;
               pass_o <= sum_ok;
               fail_o <= !sum_ok;
            end
         end
      end
   end
endmodule

// File: rtl/boot_table_checker.sv
module boot_table_checker #(
   parameter int unsigned W         = 16,
   parameter int unsigned HDR_WORDS = btchk_pkg::HDR_WORDS_DEF
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start_i,
   input  logic         word_vld_i,
   input  logic [W-1:0] word_i,
   input  logic         lsb_first_i,
   output logic         done_o,
   output logic         pass_o,
   output logic         fail_o,
   output logic [W-1:0] len_o
);
   localparam int unsigned BYTES   = W / 8;
   localparam int unsigned MIN_LEN = HDR_WORDS * BYTES;

   if (W % 8 != 0 || W < 16) begin : g_bad_width
      $error("boot_table_checker: W must be a multiple of 8 and at least 16");
   end
   if (HDR_WORDS < 2) begin : g_bad_hdr
      $error("boot_table_checker: header must hold size and checksum words");
   end

   logic [W-1:0] ord_word;
   logic [W-1:0] masked_word;
   logic [W-1:0] acc;
   logic [W-1:0] sum_next;
   logic         last_w;
   logic         pad_w;

   btchk_byte_order #(.W(W)) u_order (
      .raw_i  (word_i),
      .swap_i (lsb_first_i),
      .ord_o  (ord_word)
   );

   // pad byte of an odd-sized table is the second (low) byte of the final word
   assign masked_word = (last_w && pad_w) ? {ord_word[W-1:8], 8'h00} : ord_word;

   btchk_oc_adder #(.W(W)) u_add (
      .a_i (acc),
      .b_i (masked_word),
      .y_o (sum_next)
   );

   btchk_seq #(.W(W), .MIN_LEN(MIN_LEN)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .vld_i   (word_vld_i),
      .word_i  (ord_word),
      .sum_i   (sum_next),
      .acc_o   (acc),
      .last_o  (last_w),
      .pad_o   (pad_w),
      .done_o  (done_o),
      .pass_o  (pass_o),
      .fail_o  (fail_o),
      .len_o   (len_o)
   );
endmodule

// File: rtl/btchk_sva.sv
module btchk_sva #(
   parameter int unsigned W       = 16,
   parameter int unsigned MIN_LEN = 22
) (
   input logic         clk,
   input logic         rst_n,
   input logic         start_i,
   input logic         done_o,
   input logic         pass_o,
   input logic         fail_o,
   input logic [W-1:0] len_o
);
   // R7
   flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(pass_o && fail_o));

   // R7
   verdict_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (pass_o != fail_o));

   // R7
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R7
   pass_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pass_o && !start_i) |=> pass_o);

   // R9
   start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (!done_o && !pass_o && !fail_o && len_o == '0));

   // R5
   short_len_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && len_o < W'(MIN_LEN)) |-> fail_o);
endmodule

bind boot_table_checker btchk_sva #(.W(W), .MIN_LEN(MIN_LEN)) u_sva (
   .clk     (clk),
   .rst_n   (rst_n),
   .start_i (start_i),
   .done_o  (done_o),
   .pass_o  (pass_o),
   .fail_o  (fail_o),
   .len_o   (len_o)
);

// File: tb/tb_boot_table_checker.sv
`timescale 1ns/1ps
module tb_boot_table_checker;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        vld = 1'b0;
   logic        lsb = 1'b0;
   logic [15:0] wd = '0;
   logic        done, pass, fail;
   logic [15:0] len;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;
   logic [15:0] tbl [0:63];

   always #2.5 clk = ~clk;

   boot_table_checker dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start),
      .word_vld_i  (vld),
      .word_i      (wd),
      .lsb_first_i (lsb),
      .done_o      (done),
      .pass_o      (pass),
      .fail_o      (fail),
      .len_o       (len)
   );

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] oc_add(logic [15:0] a, logic [15:0] b);
      logic [16:0] s;
      s = {1'b0, a} + {1'b0, b};
      return s[15:0] + {15'b0, s[16]};
   endfunction

   // builds a table of len_b bytes, sealed with a valid checksum
   task automatic build(int len_b, int seed);
      int n;
      logic [15:0] s;
      n = (len_b + 1) / 2;
      tbl[0] = 16'(len_b);
      tbl[1] = 16'h0000;
      for (int i = 2; i < n; i++) tbl[i] = 16'(i * 40503 + seed * 977) ^ 16'hA5C3;
      s = 16'h0000;
      for (int i = 0; i < n; i++) begin
         if (i == n - 1 && (len_b % 2) == 1) s = oc_add(s, {tbl[i][15:8], 8'h00});
         else s = oc_add(s, tbl[i]);
      end
      tbl[1] = ~s;
   endtask

   task automatic do_start(bit with_word);
      @(negedge clk);
      start = 1'b1;
      vld = with_word;
      wd = 16'hDEAD;
      @(negedge clk);
      start = 1'b0;
      vld = 1'b0;
      chk("R9", "done after start", 32'(done), 0);
      chk("R9", "pass after start", 32'(pass), 0);
      chk("R9", "fail after start", 32'(fail), 0);
      chk("R9", "len after start", 32'(len), 0);
   endtask

   task automatic send(int first, int count, bit swap, int gap);
      for (int i = first; i < first + count; i++) begin
         if (gap > 0 && (i % 3) == 1) begin
            repeat (gap) begin
               @(negedge clk);
               vld = 1'b0;
               wd = 16'h5A5A;   // R8: garbage while valid is low
            end
         end
         @(negedge clk);
         vld = 1'b1;
         wd = swap ? {tbl[i][7:0], tbl[i][15:8]} : tbl[i];
      end
      @(negedge clk);
      vld = 1'b0;
   endtask

   task automatic expect_result(string req, bit exp_pass, int exp_len);
      chk(req, "done pulse", 32'(done), 1);
      chk(req, "pass", 32'(pass), 32'(exp_pass));
      chk(req, "fail", 32'(fail), 32'(!exp_pass));
      chk("R1", "captured size", 32'(len), 32'(exp_len));
      @(negedge clk);
      chk("R7", "done falls", 32'(done), 0);
      chk("R7", "pass held", 32'(pass), 32'(exp_pass));
      chk("R7", "fail held", 32'(fail), 32'(!exp_pass));
   endtask

   task automatic t_reset();
      chk("R10", "done at reset", 32'(done), 0);
      chk("R10", "pass at reset", 32'(pass), 0);
      chk("R10", "fail at reset", 32'(fail), 0);
      chk("R10", "len at reset", 32'(len), 0);
   endtask

   task automatic t_header_only();   // R3 minimal table
      build(22, 1);
      do_start(0);
      send(0, 11, 0, 0);
      expect_result("R3", 1, 22);
   endtask

   task automatic t_gaps();          // R8 valid gaps with garbage
      build(40, 2);
      do_start(0);
      send(0, 20, 0, 2);
      expect_result("R8", 1, 40);
   endtask

   task automatic t_corrupt();       // R3 single flipped bit
      build(30, 3);
      tbl[5] = tbl[5] ^ 16'h0100;
      do_start(0);
      send(0, 15, 0, 0);
      expect_result("R3", 0, 30);
   endtask

   task automatic t_skip();          // R4 zero checksum disables check
      build(26, 4);
      tbl[1] = 16'h0000;
      tbl[7] = tbl[7] ^ 16'h0001;
      do_start(0);
      send(0, 13, 0, 0);
      expect_result("R4", 1, 26);
   endtask

   task automatic t_swap();          // R2 swapped byte order
      lsb = 1'b1;
      build(34, 5);
      do_start(0);
      send(0, 17, 1, 0);
      expect_result("R2", 1, 34);
      lsb = 1'b0;
   endtask

   task automatic t_odd();           // R6 pad byte forced to zero
      build(27, 6);
      tbl[13] = {tbl[13][15:8], 8'hC3};
      do_start(0);
      send(0, 14, 0, 0);
      expect_result("R6", 1, 27);
   endtask

   task automatic t_short();         // R5 then R8 words after verdict
      tbl[0] = 16'd10;
      do_start(0);
      send(0, 1, 0, 0);
      expect_result("R5", 0, 10);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         vld = 1'b1;
         wd = 16'h0016;
         @(negedge clk);
         vld = 1'b0;
         chk("R8", "no done after verdict", 32'(done), 0);
         chk("R8", "fail kept after verdict", 32'(fail), 1);
         chk("R8", "size kept after verdict", 32'(len), 10);
      end
   endtask

   task automatic t_abort();         // R9 restart mid-table
      build(30, 7);
      do_start(0);
      send(0, 6, 0, 0);
      chk("R9", "no verdict mid-table", 32'(done | pass | fail), 0);
      do_start(1);
      send(0, 15, 0, 0);
      expect_result("R9", 1, 30);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_header_only();
      t_gaps();
      t_corrupt();
      t_skip();
      t_swap();
      t_odd();
      t_short();
      t_abort();
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule